// File: doc/BRIEF.md
# Access Violation Capture and Readout Unit

This block watches a set of protected bus slaves for access violations and keeps a record of them for software. Each slave has one violation strobe. All strobes share one set of event fields: the master ID, the domain ID, the read or write direction and a 36-bit address. The access-permission decision is made upstream, so a strobe means that a violation has already been detected.

Each slave index has one status bit and one mask bit, and these bits are packed 32 to a register word. The slaves are split into groups of 32 contiguous indices. For each group the block keeps the details of the first violation it sees, together with a pending flag. Software brings one group's record into two shared debug registers with a handshake: it selects the group, starts the transfer, polls until the transfer is done and then stops it. It then clears the group's pending flag and the status bits by writing ones to them. The interrupt is asserted while an enabled, unmasked status bit is set.

Top module: `viol_capture_unit`

## Requirements
- R1: After a synchronous active-low reset, these registers are zero: every status bit, every group pending bit, the reporting enable, the group select and the transfer control. Every implemented mask bit is 1, and the interrupt is low.
- R2: Slave index m maps to word m/32, bit m%32. Mask word w sits at byte address 0x000+4w and status word w at 0x400+4w. Bits beyond the last slave index read 0 and cannot be written.
- R3: A strobe on slave m while reporting is enabled sets status bit m one cycle later. Writing 1 to a status bit clears it. Strobes while reporting is disabled change no status or pending bit.
- R4: In the control register at 0xF00, writing bit 31 enables reporting and writing bit 2 disables it. When both bits are written together, bit 2 wins. The enable reads back at bit 31.
- R5: The interrupt is high exactly when reporting is enabled and some status bit is set whose mask bit is 0.
- R6: The group pending register at 0xF10 has bit g set after an enabled strobe on any slave of group g = m/32. Writing 1 to a bit clears it.
- R7: A group keeps the fields of its first violation while its pending bit stays set. Later violations in that group set only status bits. After the pending bit is cleared, the next violation is recorded.
- R8: Software writes a one-hot group to the select register at 0xF14, then writes 1 to the transfer register at 0xF20. That register reads 0x1 until SHIFT_LAT cycles after the start write and 0x3 from then on. Writing 0 returns it to 0x0.
- R9: When a transfer completes, debug word 0 (0x900) holds, from bit 0 upward: master ID in 15:0, domain ID in 21:16, the write flag in bit 22, the read flag in bit 23, address bits 35:32 in 27:24, and zeros in 31:28. Debug word 1 (0x904) holds address bits 31:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i (combinational) |
| viol_strobe_i | input | NUM_SLAVES | One violation strobe per slave |
| viol_master_i | input | 16 | Master ID of the violating access |
| viol_domain_i | input | 6 | Domain ID of the violating access |
| viol_write_i | input | 1 | The violating access was a write |
| viol_read_i | input | 1 | The violating access was a read |
| viol_addr_i | input | 36 | Address of the violating access |
| irq_o | output | 1 | Violation interrupt |

## Verification
The hardest case to reach is a second violation in a group whose record is still held. The stimulus drives two violations into the same group, each with different event fields, before software clears the group's pending bit. The transfer must then return the first violation's fields, while the status word shows both slave bits. After the pending bit is cleared, a third violation in that group must replace the record. The bench also drives strobes while reporting is disabled, and it writes the unimplemented top bit of the last mask word and reads it back.

// File: rtl/viol_pkg.sv
// Package: shared record type and register addresses of the violation unit.
// Assumes a 12-bit byte address space and 32-bit registers.
package viol_pkg;

    localparam int VIOL_ADDR_W = 36;

    typedef struct packed {
        logic [15:0]            master;
        logic [5:0]             domain;
        logic                   wr;
        logic                   rd;
        logic [VIOL_ADDR_W-1:0] addr;
    } viol_rec_t;

    localparam logic [11:0] A_DBG0  = 12'h900;
    localparam logic [11:0] A_DBG1  = 12'h904;
    localparam logic [11:0] A_CTRL  = 12'hF00;
    localparam logic [11:0] A_PEND  = 12'hF10;
    localparam logic [11:0] A_SEL   = 12'hF14;
    localparam logic [11:0] A_XFER  = 12'hF20;

    localparam int CTRL_EN_BIT   = 31;
    localparam int CTRL_STOP_BIT = 2;

endpackage

// File: rtl/viol_status_array.sv
// Module: per-slave status and mask words, and the interrupt.
// Status bits are set by enabled strobes and cleared when 1 is written to them.
// Bits at or above NUM_SLAVES are tied to 0.
module viol_status_array #(
    parameter int NUM_SLAVES = 511,
    parameter int NUM_WORDS  = 16,
    parameter int WSEL_W     = 4,
    localparam int TOT       = NUM_WORDS * 32
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              enable_i,
    input  logic [TOT-1:0]    strobe_i,
    input  logic              mask_we_i,
    input  logic              status_clr_i,
    input  logic [WSEL_W-1:0] word_sel_i,
    input  logic [31:0]       wdata_i,
    output logic [TOT-1:0]    mask_o,
    output logic [TOT-1:0]    status_o,
    output logic              irq_o
);

    localparam logic [TOT-1:0] VALID = TOT'({NUM_SLAVES{1'b1}});

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam logic [31:0] VW = VALID[w*32 +: 32];
        logic sel_w;
        assign sel_w = (32'(word_sel_i) == w);

        // Mask word: resets to all implemented bits masked, replaced on write.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)
                mask_o[w*32 +: 32] <= VW;
            else if (mask_we_i && sel_w)
                mask_o[w*32 +: 32] <= wdata_i & VW;
        end

        // Status word: write-one-to-clear, a strobe in the same cycle wins.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)
                status_o[w*32 +: 32] <= '0;
            else
                status_o[w*32 +: 32] <=
                    ((status_o[w*32 +: 32] & ~((status_clr_i && sel_w) ? wdata_i : 32'd0))
                     | (enable_i ? strobe_i[w*32 +: 32] : 32'd0)) & VW;
        end
    end

    // Interrupt: any unmasked status bit, gated by the enable.
    assign irq_o = enable_i && |(status_o & ~mask_o);

endmodule

// File: rtl/viol_group_store.sv
// Module: per-group pending flag and first-violation record.
// A group is 32 contiguous slave indices. The record is written only when the
// group is not pending, or when its pending bit is cleared in the same cycle.
module viol_group_store
    import viol_pkg::*;
#(
    parameter int NUM_GROUPS = 16,
    localparam int TOT       = NUM_GROUPS * 32
) (
    input  logic                       clk_i,
    input  logic                       rst_n_i,
    input  logic                       enable_i,
    input  logic [TOT-1:0]             strobe_i,
    input  viol_rec_t                  info_i,
    input  logic                       pend_clr_i,
    input  logic [NUM_GROUPS-1:0]      clr_bits_i,
    output logic [NUM_GROUPS-1:0]      pending_o,
    output viol_rec_t [NUM_GROUPS-1:0] records_o
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic hit, clr;
        assign hit = enable_i && |strobe_i[g*32 +: 32];
        assign clr = pend_clr_i && clr_bits_i[g];

        // Pending flag: set by a hit, cleared by writing 1; a hit wins.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)
                pending_o[g] <= 1'b0;
            else
                pending_o[g] <= (pending_o[g] && !clr) || hit;
        end

        // Record: capture the first violation while the group is free.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i)
                records_o[g] <= '0;
            else if (hit && (!pending_o[g] || clr))
                records_o[g] <= info_i;
        end
    end

endmodule

// File: rtl/viol_shift_ctrl.sv
// Module: group select, transfer handshake and the two debug words.
// Assumes software keeps the start bit set until done is seen. If several
// select bits are set, the lowest one is used.
module viol_shift_ctrl
    import viol_pkg::*;
#(
    parameter int NUM_GROUPS = 16,
    parameter int SHIFT_LAT  = 4,
    localparam int CNT_W     = $clog2(SHIFT_LAT + 1)
) (
    input  logic                       clk_i,
    input  logic                       rst_n_i,
    input  logic                       sel_we_i,
    input  logic                       xfer_we_i,
    input  logic [NUM_GROUPS-1:0]      sel_data_i,
    input  logic                       xfer_start_i,
    input  viol_rec_t [NUM_GROUPS-1:0] records_i,
    output logic [NUM_GROUPS-1:0]      sel_o,
    output logic [1:0]                 xfer_o,
    output logic [31:0]                dbg0_o,
    output logic [31:0]                dbg1_o
);

    logic             start_q, done_q;
    logic [CNT_W-1:0] cnt_q;
    viol_rec_t        pick;

    assign xfer_o = {done_q, start_q};

    // Group select register.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            sel_o <= '0;
        else if (sel_we_i)
            sel_o <= sel_data_i;
    end

    // Record mux: the lowest selected group wins.
    always_comb begin
        pick = '0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--)
            if (sel_o[g]) pick = records_i[g];
    end

    // Handshake: count the latency after start, then raise done and load the words.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            cnt_q   <= '0;
            dbg0_o  <= '0;
            dbg1_o  <= '0;
        end else if (xfer_we_i) begin
            start_q <= xfer_start_i;
            if (!xfer_start_i) begin
                done_q <= 1'b0;
                cnt_q  <= '0;
            end
        end else if (start_q && !done_q) begin
            if (32'(cnt_q) == SHIFT_LAT - 1) begin
                done_q <= 1'b1;
                dbg0_o <= {4'h0, pick.addr[35:32], pick.rd, pick.wr, pick.domain, pick.master};
                dbg1_o <= pick.addr[31:0];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/viol_capture_unit.sv
// Module: top of the violation capture unit. It decodes the register
// interface and ties together the status array, the group store and the
// transfer control. Reads are combinational on addr_i.
// Assumes NUM_SLAVES <= 1024, so that there are at most 32 groups.
module viol_capture_unit
    import viol_pkg::*;
#(
    parameter int NUM_SLAVES = 511,
    parameter int SHIFT_LAT  = 4,
    localparam int NUM_WORDS = (NUM_SLAVES + 31) / 32,
    localparam int TOT       = NUM_WORDS * 32,
    localparam int WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_n_i,
    input  logic                  wr_en_i,
    input  logic [11:0]           addr_i,
    input  logic [31:0]           wdata_i,
    output logic [31:0]           rdata_o,
    input  logic [NUM_SLAVES-1:0] viol_strobe_i,
    input  logic [15:0]           viol_master_i,
    input  logic [5:0]            viol_domain_i,
    input  logic                  viol_write_i,
    input  logic                  viol_read_i,
    input  logic [35:0]           viol_addr_i,
    output logic                  irq_o
);

    logic [TOT-1:0]              strobe_pad, mask_q, status_q;
    logic [NUM_WORDS-1:0]        pending_q, sel_q;
    viol_rec_t [NUM_WORDS-1:0]   records;
    viol_rec_t                   info;
    logic [1:0]                  xfer_q;
    logic [31:0]                 dbg0_q, dbg1_q;
    logic                        ctrl_en_q;
    logic [7:0]                  word_idx;
    logic                        word_ok, mask_we, stat_clr;
    logic                        unused_addr;

    assign unused_addr = ^addr_i[1:0];
    assign strobe_pad  = TOT'(viol_strobe_i);
    assign info        = '{master: viol_master_i, domain: viol_domain_i,
                           wr: viol_write_i, rd: viol_read_i, addr: viol_addr_i};
    assign word_idx    = addr_i[9:2];
    assign word_ok     = 32'(word_idx) < NUM_WORDS;
    assign mask_we     = wr_en_i && addr_i[11:10] == 2'b00 && word_ok;
    assign stat_clr    = wr_en_i && addr_i[11:10] == 2'b01 && word_ok;

    // Reporting enable: the stop bit has priority over the enable bit.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)
            ctrl_en_q <= 1'b0;
        else if (wr_en_i && addr_i == A_CTRL) begin
            if (wdata_i[CTRL_STOP_BIT])     ctrl_en_q <= 1'b0;
            else if (wdata_i[CTRL_EN_BIT])  ctrl_en_q <= 1'b1;
        end
    end

    viol_status_array #(
        .NUM_SLAVES(NUM_SLAVES), .NUM_WORDS(NUM_WORDS), .WSEL_W(WSEL_W)
    ) u_status (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .enable_i(ctrl_en_q),
        .strobe_i(strobe_pad), .mask_we_i(mask_we), .status_clr_i(stat_clr),
        .word_sel_i(word_idx[WSEL_W-1:0]), .wdata_i(wdata_i),
        .mask_o(mask_q), .status_o(status_q), .irq_o(irq_o)
    );

    viol_group_store #(.NUM_GROUPS(NUM_WORDS)) u_groups (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .enable_i(ctrl_en_q),
        .strobe_i(strobe_pad), .info_i(info),
        .pend_clr_i(wr_en_i && addr_i == A_PEND),
        .clr_bits_i(wdata_i[NUM_WORDS-1:0]),
        .pending_o(pending_q), .records_o(records)
    );

    viol_shift_ctrl #(.NUM_GROUPS(NUM_WORDS), .SHIFT_LAT(SHIFT_LAT)) u_shift (
        .clk_i(clk_i), .rst_n_i(rst_n_i),
        .sel_we_i(wr_en_i && addr_i == A_SEL),
        .xfer_we_i(wr_en_i && addr_i == A_XFER),
        .sel_data_i(wdata_i[NUM_WORDS-1:0]), .xfer_start_i(wdata_i[0]),
        .records_i(records), .sel_o(sel_q), .xfer_o(xfer_q),
        .dbg0_o(dbg0_q), .dbg1_o(dbg1_q)
    );

    // Read mux over all register regions.
    always_comb begin
        rdata_o = 32'd0;
        if (addr_i[11:10] == 2'b00 && word_ok)
            rdata_o = mask_q[32'(word_idx[WSEL_W-1:0]) * 32 +: 32];
        else if (addr_i[11:10] == 2'b01 && word_ok)
            rdata_o = status_q[32'(word_idx[WSEL_W-1:0]) * 32 +: 32];
        else begin
            case (addr_i)
                A_DBG0:  rdata_o = dbg0_q;
                A_DBG1:  rdata_o = dbg1_q;
                A_CTRL:  rdata_o = {ctrl_en_q, 31'd0};
                A_PEND:  rdata_o = 32'(pending_q);
                A_SEL:   rdata_o = 32'(sel_q);
                A_XFER:  rdata_o = 32'(xfer_q);
                default: rdata_o = 32'd0;
            endcase
        end
    end

endmodule

// File: rtl/viol_capture_chk.sv
// Checker: temporal properties of the violation unit, bound to the top.
module viol_capture_chk
    import viol_pkg::*;
#(
    parameter int NUM_SLAVES = 511,
    parameter int NUM_GROUPS = 16
) (
    input logic                       clk_i,
    input logic                       rst_n_i,
    input logic                       wr_en_i,
    input logic [11:0]                addr_i,
    input logic [31:0]                wdata_i,
    input logic [NUM_SLAVES-1:0]      viol_strobe_i,
    input logic                       irq_o,
    input logic                       ctrl_en_q,
    input logic [1:0]                 xfer_q,
    input logic [NUM_GROUPS*32-1:0]   status_q,
    input logic [NUM_GROUPS-1:0]      pending_q,
    input viol_rec_t [NUM_GROUPS-1:0] records
);

    // R5: the interrupt never rises while reporting is disabled.
    p_irq_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        irq_o |-> ctrl_en_q);

    // R3: an enabled strobe leaves its status bit set on the next cycle.
    p_status_set_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ctrl_en_q && viol_strobe_i != '0) |=>
        ((status_q[NUM_SLAVES-1:0] & $past(viol_strobe_i)) == $past(viol_strobe_i)));

    // R8: done rises only while the start bit is held.
    p_done_after_start_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(xfer_q[1]) |-> xfer_q[0]);

    // R8: writing 0 to the transfer register drops done.
    p_stop_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wr_en_i && addr_i == A_XFER && !wdata_i[0]) |=> (xfer_q == 2'b00));

    // R7: a held record does not change while its group stays pending.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_rec
        logic clr_g;
        assign clr_g = wr_en_i && addr_i == A_PEND && wdata_i[g];
        p_record_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (pending_q[g] && !clr_g) |=> $stable(records[g]));
    end

endmodule

bind viol_capture_unit viol_capture_chk #(
    .NUM_SLAVES(NUM_SLAVES), .NUM_GROUPS(NUM_WORDS)
) u_chk (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .viol_strobe_i(viol_strobe_i), .irq_o(irq_o),
    .ctrl_en_q(ctrl_en_q), .xfer_q(xfer_q), .status_q(status_q),
    .pending_q(pending_q), .records(records)
);

// File: tb/sim_viol_capture_unit.sv
`timescale 1ns/1ps
// Bench: a table of violation vectors walked by one loop, then directed tests.
module sim_viol_capture_unit;

    localparam int NS  = 511;
    localparam int LAT = 4;

    logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, vw = 1'b0, vr = 1'b0, irq;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0, rdata;
    logic [NS-1:0] strobe = '0;
    logic [15:0]   vm = '0;
    logic [5:0]    vd = '0;
    logic [35:0]   va = '0;
    int            n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    viol_capture_unit #(.NUM_SLAVES(NS), .SHIFT_LAT(LAT)) u0 (
        .clk_i(clk), .rst_n_i(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .viol_strobe_i(strobe),
        .viol_master_i(vm), .viol_domain_i(vd), .viol_write_i(vw),
        .viol_read_i(vr), .viol_addr_i(va), .irq_o(irq)
    );

    // Each entry: slave index, master, domain, write, read, address.
    localparam logic [68:0] VECS [6] = '{
        {9'd0,   16'h1234, 6'd3,  1'b1, 1'b0, 36'h1_8000_0040},
        {9'd37,  16'hBEEF, 6'd63, 1'b0, 1'b1, 36'hF_0000_1000},
        {9'd100, 16'h0001, 6'd0,  1'b1, 1'b0, 36'h0_DEAD_BEEC},
        {9'd255, 16'hFFFF, 6'd21, 1'b0, 1'b1, 36'h7_1234_5678},
        {9'd300, 16'h5A5A, 6'd42, 1'b1, 1'b0, 36'hA_0000_0004},
        {9'd510, 16'h8001, 6'd1,  1'b0, 1'b1, 36'h3_FFFF_FFFC}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic fire(input int idx, input logic [15:0] m, input logic [5:0] dm,
                        input logic w, input logic r, input logic [35:0] ad);
        @(negedge clk);
        strobe = '0; strobe[idx] = 1'b1; vm = m; vd = dm; vw = w; vr = r; va = ad;
        @(negedge clk); strobe = '0;
    endtask

    // Runs the full transfer handshake on group g and checks both debug words.
    task automatic readout(input int g, input logic [31:0] e0, input logic [31:0] e1);
        logic [31:0] d;
        wr(12'hF14, 32'd1 << g);
        wr(12'hF20, 32'd1);
        rd(12'hF20, d);
        check("R8 transfer busy", d, 32'd1);
        for (int i = 0; i < 16 && d != 32'd3; i++) rd(12'hF20, d);
        check("R8 transfer done", d, 32'd3);
        rd(12'h900, d); check("R9 debug word 0", d, e0);
        rd(12'h904, d); check("R9 debug word 1", d, e1);
        wr(12'hF20, 32'd0);
        rd(12'hF20, d); check("R8 transfer stopped", d, 32'd0);
    endtask

    function automatic logic [31:0] dbg0(input logic [15:0] m, input logic [5:0] dm,
                                         input logic w, input logic r, input logic [35:0] a);
        return {4'h0, a[35:32], r, w, dm, m};
    endfunction

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        rd(12'h000, d); check("R1 mask word 0", d, 32'hFFFF_FFFF);
        rd(12'h03C, d); check("R2 last mask word partial", d, 32'h7FFF_FFFF);
        rd(12'h400, d); check("R1 status word 0", d, 32'd0);
        rd(12'hF00, d); check("R1 enable", d, 32'd0);
        rd(12'hF10, d); check("R1 pending", d, 32'd0);
        rd(12'hF20, d); check("R1 transfer", d, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R3: strobes while disabled are ignored.
        fire(5, 16'h1111, 6'd1, 1'b1, 1'b0, 36'h0);
        rd(12'h400, d); check("R3 disabled strobe status", d, 32'd0);
        rd(12'hF10, d); check("R6 disabled strobe pending", d, 32'd0);

        // R4: enable.
        wr(12'hF00, 32'h8000_0000);
        rd(12'hF00, d); check("R4 enable read", d, 32'h8000_0000);

        // Vector table walk.
        foreach (VECS[k]) begin
            int          idx;
            logic [15:0] m;
            logic [5:0]  dm;
            logic        w, r;
            logic [35:0] a;
            {idx, m, dm, w, r, a} = {23'd0, VECS[k]};
            fire(idx, m, dm, w, r, a);
            rd(12'(12'h400 + 4 * (idx / 32)), d);
            check("R2 R3 status bit", d, 32'd1 << (idx % 32));
            rd(12'hF10, d); check("R6 group pending", d, 32'd1 << (idx / 32));
            check("R5 irq masked", {31'd0, irq}, 32'd0);
            readout(idx / 32, dbg0(m, dm, w, r, a), a[31:0]);
            wr(12'hF10, 32'd1 << (idx / 32));
            rd(12'hF10, d); check("R6 pending cleared", d, 32'd0);
            wr(12'(12'h400 + 4 * (idx / 32)), 32'hFFFF_FFFF);
            rd(12'(12'h400 + 4 * (idx / 32)), d); check("R3 status cleared", d, 32'd0);
        end

        // R5: the interrupt follows the unmasked status.
        fire(40, 16'h0040, 6'd4, 1'b0, 1'b1, 36'h40);
        check("R5 irq while masked", {31'd0, irq}, 32'd0);
        wr(12'h004, 32'hFFFF_FEFF);
        check("R5 irq unmasked", {31'd0, irq}, 32'd1);
        wr(12'h404, 32'h0000_0100);
        check("R5 irq after status clear", {31'd0, irq}, 32'd0);
        wr(12'hF10, 32'h2);

        // R7: the first record is kept; the next one is taken after clearing.
        fire(70, 16'hAAAA, 6'd10, 1'b1, 1'b0, 36'h2_0000_0070);
        fire(71, 16'hBBBB, 6'd11, 1'b0, 1'b1, 36'h3_0000_0071);
        rd(12'h408, d); check("R7 both status bits", d, 32'h0000_00C0);
        readout(2, dbg0(16'hAAAA, 6'd10, 1'b1, 1'b0, 36'h2_0000_0070), 32'h70);
        wr(12'hF10, 32'h4);
        fire(72, 16'hCCCC, 6'd12, 1'b0, 1'b1, 36'h4_0000_0072);
        readout(2, dbg0(16'hCCCC, 6'd12, 1'b0, 1'b1, 36'h4_0000_0072), 32'h72);

        // R4, R5: the stop bit wins and gates the interrupt.
        fire(40, 16'h0040, 6'd4, 1'b0, 1'b1, 36'h40);
        check("R5 irq set again", {31'd0, irq}, 32'd1);
        wr(12'hF00, 32'h8000_0004);
        rd(12'hF00, d); check("R4 stop wins", d, 32'd0);
        check("R5 irq gated by enable", {31'd0, irq}, 32'd0);

        // R2: the unimplemented top bit of the last mask word.
        wr(12'h03C, 32'd0);
        rd(12'h03C, d); check("R2 last mask word written", d, 32'd0);
        wr(12'h03C, 32'hFFFF_FFFF);
        rd(12'h03C, d); check("R2 pad bit stays zero", d, 32'h7FFF_FFFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule